// File: doc/BRIEF.md
# CAN Message Acceptance Mask Filter

This block holds the acceptance settings of a single CAN message object and decides, frame by frame, whether that object takes a received frame. The settings are an identifier, an extended-format flag, a direction flag, a message-valid flag, a per-bit identifier mask and two enables. The enables decide whether the frame's IDE bit and its direction bit take part in the compare. Software reaches these settings through a two-word register port. The port can always be read. While the external busy flag is high, writes to it are dropped.

For each received frame, the frame decoder presents the 29-bit identifier field, the IDE bit and the direction bit with a one-cycle strobe. An 11-bit standard identifier is presented left-aligned in bits 28..18. One clock later the block raises exactly one of two result pulses, accept or reject. An object whose extended flag is 0 compares only the top 11 identifier bits. An object whose extended flag is 1 compares all 29 bits. In both cases the identifier compare is gated by the mask.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, the mask word (reg_sel=0) reads 0xFFFFFFFF and the arbitration word (reg_sel=1) reads 0x00000000.
- R2: With busy low, a write stores the word and it reads back. Mask word layout: bit 31 is the IDE compare enable, bit 30 is the direction compare enable, bit 29 always reads 1 whatever was written, and bits 28..0 are the identifier mask. Arbitration word layout: bit 31 is message-valid, bit 30 is extended, bit 29 is direction, and bits 28..0 are the identifier.
- R3: A write made in a cycle where busy is high leaves both words unchanged. A write made in the first cycle busy is low again is stored.
- R4: accept or reject goes high for exactly one cycle, one clock after a frame strobe. The two are never high together, and neither is high in a cycle that does not follow a strobe.
- R5: While message-valid is 0, every frame is rejected.
- R6: For an extended object, identifier bit i must equal the stored bit when mask bit i is 1. When mask bit i is 0, that bit is ignored.
- R7: For a standard object, identifier bits 17..0 are ignored. Bits 28..18 are compared under mask bits 28..18.
- R8: With the IDE enable at 1, the frame's IDE bit must equal the stored extended flag. With the enable at 0, IDE is ignored.
- R9: With the direction enable at 1, the frame's direction bit must equal the stored direction flag. With the enable at 0, direction is ignored.
- R10: When a strobe and a register write fall in the same cycle, the compare uses the settings stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Word select: 0 selects the mask word, 1 selects the arbitration word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| busy | input | 1 | Write protection: writes are dropped while high |
| frm_valid | input | 1 | One-cycle strobe marking a received frame |
| frm_id | input | 29 | Frame identifier; a standard identifier sits in bits 28..18 |
| frm_ide | input | 1 | Frame IDE bit |
| frm_dir | input | 1 | Frame direction bit |
| acc | output | 1 | Accept pulse |
| rej | output | 1 | Reject pulse |

## Verification
The assertions assume that frm_valid is a single-cycle strobe whose fields are stable in that cycle. They also assume that busy and the write strobe are driven from the clock domain of the block. The stimulus changes every input only on the falling edge and drops the strobe after one cycle. Some checks place a strobe directly after another. Even then, each frame occupies its own distinct cycle, so every result pulse can be traced back to one strobe.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int ID_W     = 29;
    localparam int STD_W    = 11;
    localparam int STD_LSB  = ID_W - STD_W;
    localparam int WORD_W   = 32;
    localparam int BIT_HI   = WORD_W - 1;
    localparam int BIT_MID  = WORD_W - 2;
    localparam int BIT_LO   = WORD_W - 3;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_ARB  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic            ide_en;
        logic            dir_en;
        logic [ID_W-1:0] bits;
    } flt_mask_t;

    typedef struct packed {
        logic            valid;
        logic            ext;
        logic            dir;
        logic [ID_W-1:0] id;
    } flt_arb_t;

    localparam flt_mask_t MASK_RST = '{ide_en: 1'b1, dir_en: 1'b1, bits: '1};
    localparam flt_arb_t  ARB_RST  = '{valid: 1'b0, ext: 1'b0, dir: 1'b0, id: '0};

    function automatic flt_mask_t word_to_mask(input logic [WORD_W-1:0] w);
        flt_mask_t m;
        m.ide_en = w[BIT_HI];
        m.dir_en = w[BIT_MID];
        m.bits   = w[ID_W-1:0];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] mask_to_word(input flt_mask_t m);
        return {m.ide_en, m.dir_en, 1'b1, m.bits};
    endfunction

    function automatic flt_arb_t word_to_arb(input logic [WORD_W-1:0] w);
        flt_arb_t a;
        a.valid = w[BIT_HI];
        a.ext   = w[BIT_MID];
        a.dir   = w[BIT_LO];
        a.id    = w[ID_W-1:0];
        return a;
    endfunction

    function automatic logic [WORD_W-1:0] arb_to_word(input flt_arb_t a);
        return {a.valid, a.ext, a.dir, a.id};
    endfunction

endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
    import can_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic [WORD_W-1:0] rdata,
    output flt_mask_t         mask_o,
    output flt_arb_t          arb_o
);

    typedef struct packed {
        flt_mask_t mask;
        flt_arb_t  arb;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_ok;

    always_comb begin
        regs_d = regs_q;
        wr_ok  = wr && !busy;
        if (wr_ok) begin
            if (reg_sel_e'(sel) == SEL_MASK) begin
                regs_d.mask = word_to_mask(wdata);
            end else begin
                regs_d.arb  = word_to_arb(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{mask: MASK_RST, arb: ARB_RST};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata  = (reg_sel_e'(sel) == SEL_MASK) ? mask_to_word(regs_q.mask)
                                                  : arb_to_word(regs_q.arb);
    assign mask_o = regs_q.mask;
    assign arb_o  = regs_q.arb;

    a_r3_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(regs_q));

    a_r2_arb_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !busy && sel) |=> (arb_to_word(arb_o) == $past(wdata)));

    a_r2_reserved_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> rdata[BIT_LO]);

endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
    import can_flt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  flt_mask_t       mask,
    input  flt_arb_t        arb,
    input  logic [ID_W-1:0] frm_id,
    input  logic            frm_ide,
    input  logic            frm_dir,
    output logic            hit
);

    logic [ID_W-1:0] care;
    logic [ID_W-1:0] diff;
    logic            id_ok;
    logic            ide_ok;
    logic            dir_ok;

    for (genvar i = 0; i < ID_W; i++) begin : g_care
        if (i >= STD_LSB) begin : g_std
            assign care[i] = mask.bits[i];
        end else begin : g_ext
            assign care[i] = mask.bits[i] & arb.ext;
        end
    end

    always_comb begin
        diff   = (frm_id ^ arb.id) & care;
        id_ok  = (diff == '0);
        ide_ok = !mask.ide_en || (frm_ide == arb.ext);
        dir_ok = !mask.dir_en || (frm_dir == arb.dir);
        hit    = arb.valid && id_ok && ide_ok && dir_ok;
    end

    a_r5_invalid_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        !arb.valid |-> !hit);

    a_r8_ide_mismatch_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (mask.ide_en && (frm_ide != arb.ext)) |-> !hit);

    a_r9_dir_mismatch_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (mask.dir_en && (frm_dir != arb.dir)) |-> !hit);

    a_r7_std_low_bits_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb.ext && arb.valid && !mask.ide_en && !mask.dir_en
         && (frm_id[ID_W-1:STD_LSB] == arb.id[ID_W-1:STD_LSB])) |-> hit);

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_dir,
    output logic              acc,
    output logic              rej
);

    typedef struct packed {
        logic acc;
        logic rej;
    } res_t;

    flt_mask_t mask;
    flt_arb_t  arb;
    logic      hit;
    res_t      res_d, res_q;

    can_flt_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .rdata  (reg_rdata),
        .mask_o (mask),
        .arb_o  (arb)
    );

    can_flt_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask    (mask),
        .arb     (arb),
        .frm_id  (frm_id),
        .frm_ide (frm_ide),
        .frm_dir (frm_dir),
        .hit     (hit)
    );

    always_comb begin
        res_d = '0;
        if (frm_valid) begin
            res_d.acc = hit;
            res_d.rej = !hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc = res_q.acc;
    assign rej = res_q.rej;

    a_r4_strobe_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (acc ^ rej));

    a_r4_no_strobe_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !(acc || rej));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc, rej}));

    a_r5_invalid_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !arb.valid) |=> rej);

endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
    import can_flt_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_sel = 1'b0;
    logic              reg_wr = 1'b0;
    logic [WORD_W-1:0] reg_wdata = '0;
    logic [WORD_W-1:0] reg_rdata;
    logic              busy = 1'b0;
    logic              frm_valid = 1'b0;
    logic [ID_W-1:0]   frm_id = '0;
    logic              frm_ide = 1'b0;
    logic              frm_dir = 1'b0;
    logic              acc;
    logic              rej;

    int n_chk  = 0;
    int n_fail = 0;

    logic [WORD_W-1:0] sh_mask = 32'hFFFF_FFFF;
    logic [WORD_W-1:0] sh_arb  = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .frm_valid (frm_valid),
        .frm_id    (frm_id),
        .frm_ide   (frm_ide),
        .frm_dir   (frm_dir),
        .acc       (acc),
        .rej       (rej)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected decision worked out from R5..R9
    function automatic logic model(input logic [31:0] m, input logic [31:0] a,
                                   input logic [ID_W-1:0] id, input logic ide,
                                   input logic dir);
        logic [ID_W-1:0] care;
        care = m[ID_W-1:0];
        if (!a[30]) care = care & {{STD_W{1'b1}}, {STD_LSB{1'b0}}};
        if (!a[31]) return 1'b0;
        if (((id ^ a[ID_W-1:0]) & care) != '0) return 1'b0;
        if (m[31] && (ide != a[30])) return 1'b0;
        if (m[30] && (dir != a[29])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wr_reg(input logic sel, input logic [31:0] d, input logic bsy);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d; busy = bsy;
        @(negedge clk);
        reg_wr = 1'b0; busy = 1'b0;
        if (!bsy) begin
            if (sel) sh_arb = d;
            else     sh_mask = d | 32'h2000_0000;
        end
    endtask

    task automatic rd_chk(input string req, input logic sel, input logic [31:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic frame(input string req, input logic [ID_W-1:0] id,
                         input logic ide, input logic dir);
        logic e;
        e = model(sh_mask, sh_arb, id, ide, dir);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_dir = dir;
        @(negedge clk);
        frm_valid = 1'b0;
        chk(req, {30'b0, acc, rej}, {30'b0, e, !e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk("R1 mask reset", 1'b0, 32'hFFFF_FFFF);
        rd_chk("R1 arb reset",  1'b1, 32'h0000_0000);
        chk("R4 idle outputs", {30'b0, acc, rej}, 32'h0);

        // R5 invalid object rejects
        frame("R5 invalid after reset", '0, 1'b0, 1'b0);

        // R2 write, readback, reserved bit
        wr_reg(1'b0, 32'h1234_5678 & 32'hDFFF_FFFF, 1'b0);
        rd_chk("R2 mask readback reserved", 1'b0, sh_mask);
        wr_reg(1'b1, 32'hC0AB_CDEF, 1'b0);
        rd_chk("R2 arb readback", 1'b1, 32'hC0AB_CDEF);

        // R3 busy blocks, release cycle accepts
        wr_reg(1'b1, 32'h1111_1111, 1'b1);
        rd_chk("R3 busy arb kept", 1'b1, 32'hC0AB_CDEF);
        wr_reg(1'b0, 32'h0, 1'b1);
        rd_chk("R3 busy mask kept", 1'b0, sh_mask);
        @(negedge clk); busy = 1'b1;
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hA000_0005; busy = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; sh_arb = 32'hA000_0005;
        rd_chk("R3 write on busy release", 1'b1, 32'hA000_0005);

        // R6 extended object, per-bit mask sweep
        for (int p = 0; p < 2; p++) begin
            wr_reg(1'b0, (p == 0) ? 32'h0AAA_AAAA : 32'h1555_5555, 1'b0);
            wr_reg(1'b1, 32'hC000_0000 | (32'h0F0F_0F0F & 32'h1FFF_FFFF), 1'b0);
            for (int i = 0; i < ID_W; i++) begin
                frame("R6 ext bit flip", sh_arb[ID_W-1:0] ^ (29'd1 << i), 1'b1, 1'b0);
            end
            frame("R6 ext exact", sh_arb[ID_W-1:0], 1'b1, 1'b0);
        end

        // R7 standard object, full mask, each bit flipped
        wr_reg(1'b0, 32'h1FFF_FFFF, 1'b0);
        wr_reg(1'b1, 32'h8000_0000 | (32'h0123_4567 & 32'h1FFF_FFFF), 1'b0);
        for (int i = 0; i < ID_W; i++) begin
            frame("R7 std bit flip", sh_arb[ID_W-1:0] ^ (29'd1 << i), 1'b0, 1'b1);
        end
        wr_reg(1'b0, 32'h1FFF_FFFF & ~32'h1000_0000, 1'b0);
        frame("R7 std masked top bit", sh_arb[ID_W-1:0] ^ 29'h1000_0000, 1'b0, 1'b0);

        // R5 R8 R9 control sweep
        for (int c = 0; c < 128; c++) begin
            logic [6:0] v;
            v = 7'(c);
            wr_reg(1'b0, {v[0], v[1], 1'b0, 29'h1FFF_FFFF}, 1'b0);
            wr_reg(1'b1, {v[4], v[2], v[3], 29'h0ABC_0000}, 1'b0);
            frame("R8 R9 R5 control sweep", 29'h0ABC_0000, v[5], v[6]);
        end

        // R10 write in same cycle as strobe uses old settings
        wr_reg(1'b0, 32'h1FFF_FFFF, 1'b0);
        wr_reg(1'b1, 32'hC000_0123, 1'b0);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = 29'h123; frm_ide = 1'b1; frm_dir = 1'b0;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hC000_0456;
        @(negedge clk);
        frm_valid = 1'b0; reg_wr = 1'b0; sh_arb = 32'hC000_0456;
        chk("R10 old settings used", {30'b0, acc, rej}, 32'h2);
        frame("R10 new settings next", 29'h123, 1'b1, 1'b0);

        // R4 single-cycle pulse
        @(negedge clk);
        chk("R4 pulse ends", {30'b0, acc, rej}, 32'h0);
        frame("R4 back to back a", 29'h456, 1'b1, 1'b0);
        frame("R4 back to back b", 29'h457, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 quiet after", {30'b0, acc, rej}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule